// File: doc/BRIEF.md
# Freezable Direct-Mapped Data Cache Controller

This block is a small direct-mapped, write-through data cache that sits between a processor load/store port and a single-word memory port. Each processor access is looked up in a tag/valid/data store. The outcome is one of four: served from the cache, filled from memory, passed to memory without replacing the line, or bypassed completely. A control register selects this policy. It has an enable bit and a freeze bit, which reset clears, and a write-allocate bit.

Freeze stops all replacement on misses, but a write that hits still refreshes the cached word. Turning the cache off sends every access to memory and leaves every line untouched. Lines that were valid before the cache was turned off can hit again once it is turned back on. The store has 16 lines of one 32-bit word. Address bits [5:2] select the line and bits [31:6] form the tag.

A processor access is a one-cycle pulse on `cpu_req`, and the block ignores pulses while an access is in flight. Completion is a one-cycle `cpu_ready` pulse, and `cpu_rdata` holds the result for reads. The memory side holds `mem_req` with a stable address and data until a one-cycle `mem_ack`.

Top module: `fdc_top`

## Requirements
- R1: After reset the control register reads as zero, the cache is off, and every line is invalid, so the first enabled read of any address goes to memory.
- R2: The control register places freeze at bit 9, enable at bit 8 and write-allocate at bit 0. Every other bit reads back as zero.
- R3: With the cache on, a read whose line is valid and whose tag matches completes with `cpu_ready` in the cycle after the request. It returns the cached word and makes no memory request.
- R4: With the cache on and freeze clear, a read miss makes one memory read of the word address, returns that word, and installs it in the indexed line so that the next read of that address hits.
- R5: With freeze set, a read miss is served from memory and does not replace the indexed line. The line's previous address still hits afterwards.
- R6: With freeze set, a write miss does not replace the indexed line. The line's previous address still hits with its old data.
- R7: With freeze set, a write that hits updates the cached word, and a later read hit returns the new data.
- R8: Every write produces exactly one memory write with the request's address and data, whether it hits or misses. `mem_req`, `mem_addr` and `mem_wdata` stay stable until `mem_ack`.
- R9: With the cache on and freeze clear, a write miss installs the written word when write-allocate is set, and leaves the line unchanged when write-allocate is clear.
- R10: With the cache off, every read and write goes to memory, and no tag, valid bit or cached word changes, including on a write to a cached address.
- R11: After the cache is turned off and then on again, lines that were valid before still hit with the data they held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 32 | Control register write value |
| cfg_rdata | output | 32 | Control register read value |
| cpu_req | input | 1 | One-cycle access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read result, valid with `cpu_ready` |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory write select |
| mem_addr | output | 32 | Memory word address (byte form) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
Directed sequences use addresses that alias onto the same line with different tags. These separate a real replacement from a frozen pass-through, and a stale cached word from the current memory word. Hits and misses are distinguished at the ports by the completion latency and by counting memory transactions. Write-through is checked against the memory writes that are seen. A constrained-random phase then mixes reads and writes over four aliasing tags with random control-register values and random memory latency. It compares every result with a reference cache model kept in the bench, which separates the enable, freeze and write-allocate combinations from one another.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LINES  = 16;
    localparam int OFS_W  = $clog2(DATA_W / 8);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;

    localparam int CFG_FRZ_BIT = 9;
    localparam int CFG_EN_BIT  = 8;
    localparam int CFG_WA_BIT  = 0;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic frz;
        logic en;
        logic wa;
    } cfg_t;

    typedef struct packed {
        logic  we;
        tag_t  tag;
        idx_t  idx;
        word_t wdata;
    } req_t;

    typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_DONE} st_t;

    function automatic idx_t idx_of(input addr_t a);
        return a[OFS_W +: IDX_W];
    endfunction

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic addr_t addr_of(input tag_t t, input idx_t i);
        return {t, i, {OFS_W{1'b0}}};
    endfunction
endpackage

// File: rtl/fdc_cfg.sv
module fdc_cfg
    import fdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output cfg_t        cfg,
    output logic [31:0] rdata
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.frz <= wdata[CFG_FRZ_BIT];
            cfg_q.en  <= wdata[CFG_EN_BIT];
            cfg_q.wa  <= wdata[CFG_WA_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        rdata[CFG_FRZ_BIT] = cfg_q.frz;
        rdata[CFG_EN_BIT]  = cfg_q.en;
        rdata[CFG_WA_BIT]  = cfg_q.wa;
    end

    assign cfg = cfg_q;

    AST_CFG_RESET: assert property (@(posedge clk) rst |=> (rdata == '0)); // R1
endmodule

// File: rtl/fdc_store.sv
module fdc_store
    import fdc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  idx_t                  rd_idx,
    output logic                  rd_valid,
    output tag_t                  rd_tag,
    output word_t                 rd_data,
    input  logic                  wr_en,
    input  idx_t                  wr_idx,
    input  tag_t                  wr_tag,
    input  word_t                 wr_data,
    output logic [LINES-1:0]      valid_vec,
    output logic [LINES*TAG_W-1:0] tag_vec
);
    logic [LINES-1:0][DATA_W-1:0] data_arr;
    logic [LINES-1:0][TAG_W-1:0]  tag_arr;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic  v_q;
        tag_t  t_q;
        word_t d_q;
        logic  sel;

        assign sel = wr_en && (wr_idx == idx_t'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                t_q <= wr_tag;
                d_q <= wr_data;
            end
        end

        assign valid_vec[g] = v_q;
        assign tag_arr[g]   = t_q;
        assign data_arr[g]  = d_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];
    assign rd_data  = data_arr[rd_idx];
    assign tag_vec  = tag_arr;
endmodule

// File: rtl/fdc_ctrl.sv
module fdc_ctrl
    import fdc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  logic  cpu_req,
    input  logic  cpu_we,
    input  addr_t cpu_addr,
    input  word_t cpu_wdata,
    output logic  cpu_ready,
    output word_t cpu_rdata,
    output logic  mem_req,
    output logic  mem_we,
    output addr_t mem_addr,
    output word_t mem_wdata,
    input  logic  mem_ack,
    input  word_t mem_rdata,
    output idx_t  lk_idx,
    input  logic  lk_valid,
    input  tag_t  lk_tag,
    input  word_t lk_data,
    output logic  wr_en,
    output idx_t  wr_idx,
    output tag_t  wr_tag,
    output word_t wr_data
);
    st_t   st_q;
    req_t  req_q;
    logic  hit_q;
    word_t rdata_q;
    logic  accept;
    logic  hit_now;

    assign accept  = (st_q == ST_IDLE) && cpu_req;
    assign lk_idx  = (st_q == ST_IDLE) ? idx_of(cpu_addr) : req_q.idx;
    assign hit_now = cfg.en && lk_valid && (lk_tag == tag_of(cpu_addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            req_q   <= '0;
            hit_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (accept) begin
                    req_q.we    <= cpu_we;
                    req_q.tag   <= tag_of(cpu_addr);
                    req_q.idx   <= idx_of(cpu_addr);
                    req_q.wdata <= cpu_wdata;
                    hit_q       <= hit_now;
                    if (hit_now && !cpu_we) begin
                        rdata_q <= lk_data;
                        st_q    <= ST_DONE;
                    end else begin
                        st_q    <= ST_MEM;
                    end
                end
                ST_MEM: if (mem_ack) begin
                    if (!req_q.we) rdata_q <= mem_rdata;
                    st_q <= ST_DONE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // line update decided at the memory acknowledge
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = req_q.idx;
        wr_tag  = req_q.tag;
        wr_data = req_q.we ? req_q.wdata : mem_rdata;
        if ((st_q == ST_MEM) && mem_ack && cfg.en) begin
            if (req_q.we) begin
                if (hit_q)                   wr_en = 1'b1;
                else if (!cfg.frz && cfg.wa) wr_en = 1'b1;
            end else if (!hit_q && !cfg.frz) begin
                wr_en = 1'b1;
            end
        end
    end

    assign mem_req   = (st_q == ST_MEM);
    assign mem_we    = req_q.we;
    assign mem_addr  = addr_of(req_q.tag, req_q.idx);
    assign mem_wdata = req_q.wdata;
    assign cpu_ready = (st_q == ST_DONE);
    assign cpu_rdata = rdata_q;

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (accept && !cpu_we && cfg.en && lk_valid && (lk_tag == tag_of(cpu_addr))) |=> (cpu_ready && !mem_req)); // R3
    AST_WRITE_GOES_OUT: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_we) |=> (mem_req && mem_we)); // R8
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we))); // R8
    AST_OFF_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en) |-> !wr_en); // R10
endmodule

// File: rtl/fdc_top.sv
module fdc_top
    import fdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    cfg_t  cfg;
    idx_t  lk_idx;
    logic  lk_valid;
    tag_t  lk_tag;
    word_t lk_data;
    logic  wr_en;
    idx_t  wr_idx;
    tag_t  wr_tag;
    word_t wr_data;
    logic [LINES-1:0]       valid_vec;
    logic [LINES*TAG_W-1:0] tag_vec;

    fdc_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    fdc_store u_store (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_valid(lk_valid), .rd_tag(lk_tag), .rd_data(lk_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
        .valid_vec(valid_vec), .tag_vec(tag_vec)
    );

    fdc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cfg(cfg),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
    );

    AST_FREEZE_KEEPS_LINES: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.frz) |=> ($stable(valid_vec) && $stable(tag_vec))); // R5
    AST_FREEZE_WRITE_MISS: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.frz && mem_req && mem_we) |=> $stable(tag_vec)); // R6
    AST_OFF_KEEPS_LINES: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en) |=> ($stable(valid_vec) && $stable(tag_vec))); // R10
    AST_RESET_INVALID: assert property (@(posedge clk) rst |=> (valid_vec == '0)); // R1
endmodule

// File: tb/fdc_top_tb.sv
module fdc_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    fdc_top u_dut (.*);

    // bench memory and reference cache
    logic [31:0] mem [256];
    bit          m_valid [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_data [16];
    bit m_en, m_frz, m_wa;

    int txn_cnt = 0;
    logic [31:0] last_waddr, last_wdata;
    int mem_delay = 0;

    function automatic logic [31:0] init_word(input int i);
        return 32'hA500_0000 ^ (i * 32'h0101_0107);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && !done) begin
                if (mem_delay == 0) begin
                    if (mem_we) begin
                        mem[mem_addr[9:2]] = mem_wdata;
                        last_waddr = mem_addr;
                        last_wdata = mem_wdata;
                    end else begin
                        mem_rdata = mem[mem_addr[9:2]];
                    end
                    mem_ack = 1'b1;
                    txn_cnt++;
                    mem_delay = $urandom_range(0, 3);
                end else begin
                    mem_delay--;
                end
            end
        end
    end

    task automatic set_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        m_frz = v[9];
        m_en  = v[8];
        m_wa  = v[0];
    endtask

    // one access; returns whether it behaved as a hit, checks against the model
    task automatic access(input bit we, input int w, input logic [31:0] wd, input string tag,
                          output bit was_hit, output logic [31:0] rd);
        int idx = w % 16;
        logic [25:0] tg = 26'(w / 16);
        bit exp_hit = m_en && m_valid[idx] && (m_tag[idx] == tg);
        logic [31:0] exp_rd = (exp_hit && !we) ? m_data[idx] : mem[w];
        int t0 = txn_cnt;
        int cyc = 1;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = 32'(w) << 2; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_ready && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk(cpu_ready, tag, 32'(cyc), 32'd60);
        rd = cpu_rdata;
        was_hit = (txn_cnt == t0);
        if (!we) begin
            chk(rd == exp_rd, tag, rd, exp_rd);
            chk(was_hit == (exp_hit && 1'b1), tag, 32'(was_hit), 32'(exp_hit));
            if (exp_hit) chk(cyc == 1, tag, 32'(cyc), 32'd1);
            if (m_en && !exp_hit && !m_frz) begin
                m_valid[idx] = 1'b1; m_tag[idx] = tg; m_data[idx] = exp_rd;
            end
        end else begin
            chk((txn_cnt - t0) == 1 && last_waddr == (32'(w) << 2) && last_wdata == wd,
                "R8", last_wdata, wd);
            if (m_en && exp_hit) m_data[idx] = wd;
            else if (m_en && !m_frz && m_wa) begin
                m_valid[idx] = 1'b1; m_tag[idx] = tg; m_data[idx] = wd;
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit h;
        logic [31:0] r;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) mem[i] = init_word(i);
        for (int i = 0; i < 16; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
        m_en = 0; m_frz = 0; m_wa = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: register cleared at reset
        chk(cfg_rdata == 32'h0, "R1", cfg_rdata, 32'h0);
        // R2: bit layout
        set_cfg(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'h0000_0301, "R2", cfg_rdata, 32'h0000_0301);
        set_cfg(32'h0000_0100);
        chk(cfg_rdata == 32'h0000_0100, "R2", cfg_rdata, 32'h0000_0100);

        // R1/R4: first read misses, then hits (R3)
        access(0, 5, 0, "R1", h, r);
        chk(!h, "R1", 32'(h), 32'd0);
        access(0, 5, 0, "R3", h, r);
        chk(h && r == init_word(5), "R3", r, init_word(5));
        access(0, 21, 0, "R4", h, r);
        chk(!h && r == init_word(21), "R4", r, init_word(21));
        access(0, 21, 0, "R4", h, r);
        chk(h, "R4", 32'(h), 32'd1);
        access(0, 5, 0, "R4", h, r);
        chk(!h, "R4", 32'(h), 32'd0);

        // freeze
        set_cfg(32'h0000_0301);
        access(0, 37, 0, "R5", h, r);
        chk(!h && r == init_word(37), "R5", r, init_word(37));
        access(0, 5, 0, "R5", h, r);
        chk(h, "R5", 32'(h), 32'd1);
        access(1, 53, 32'h1111_2222, "R6", h, r);
        access(0, 5, 0, "R6", h, r);
        chk(h && r == init_word(5), "R6", r, init_word(5));
        access(1, 5, 32'hCAFE_0005, "R7", h, r);
        chk(mem[5] == 32'hCAFE_0005, "R8", mem[5], 32'hCAFE_0005);
        access(0, 5, 0, "R7", h, r);
        chk(h && r == 32'hCAFE_0005, "R7", r, 32'hCAFE_0005);

        // write-allocate
        set_cfg(32'h0000_0100);
        access(1, 6, 32'h0000_6666, "R9", h, r);
        access(0, 6, 0, "R9", h, r);
        chk(!h, "R9", 32'(h), 32'd0);
        set_cfg(32'h0000_0101);
        access(1, 7, 32'h0000_7777, "R9", h, r);
        access(0, 7, 0, "R9", h, r);
        chk(h && r == 32'h0000_7777, "R9", r, 32'h0000_7777);

        // disable and re-enable
        set_cfg(32'h0000_0001);
        access(0, 5, 0, "R10", h, r);
        chk(!h && r == 32'hCAFE_0005, "R10", r, 32'hCAFE_0005);
        access(1, 5, 32'hBEEF_0005, "R10", h, r);
        access(1, 8, 32'h0000_8888, "R10", h, r);
        access(0, 5, 0, "R10", h, r);
        chk(!h && r == 32'hBEEF_0005, "R10", r, 32'hBEEF_0005);
        set_cfg(32'h0000_0100);
        access(0, 5, 0, "R11", h, r);
        chk(h && r == 32'hCAFE_0005, "R11", r, 32'hCAFE_0005);
        access(0, 7, 0, "R11", h, r);
        chk(h && r == 32'h0000_7777, "R11", r, 32'h0000_7777);
        access(0, 8, 0, "R10", h, r);
        chk(!h, "R10", 32'(h), 32'd0);

        // random mix
        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(0, 15) == 0) begin
                logic [31:0] v = 32'h0;
                v[9] = 1'($urandom_range(0, 1));
                v[8] = ($urandom_range(0, 3) != 0);
                v[0] = 1'($urandom_range(0, 1));
                set_cfg(v);
            end
            begin
                bit we = 1'($urandom_range(0, 1));
                int w = ($urandom_range(0, 3) * 16) + $urandom_range(0, 15);
                string tg = we ? "R8" : (!m_en ? "R10" : (m_frz ? "R5" : "R4"));
                access(we, w, $urandom, tg, h, r);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule